// File: doc/BRIEF.md
# Masked Interrupt Aggregator for a Random Number Generator

This block gathers the event flags of a random number generator core and turns them into one interrupt line. Three core flags are kept: a generation-complete flag, a health-test failure flag and a continuous-test failure flag. Each has its own enable bit. When the flags or enables change, the enabled flags are ORed into a single core-interrupt bit. Software clears the flags one at a time through dedicated clear bits.

The core-interrupt bit and a bus-error bit form a two-bit top-level status word. Software clears its bits by writing ones. A two-bit mask selects which status bits reach the `irq` output. The mask cannot be written directly: an unmask port clears mask bits and a mask-set port sets them. Test logic can inject health-test and continuous-test failures as single-cycle pulses. Injections are dropped while the entropy source is off. On cores older than version 0x0200, an injected continuous-test failure is also dropped unless the test-unit enable bit is set. The hardware version also decides which control writes are accepted.

Register access uses a synchronous write port and a combinational read port. Both are word-addressed with a three-bit index.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask reads 0x3, the top-level status reads 0, the flag word reads 0 and `irq` is low.
- R2: Status (index 4): bit 0 is the core-interrupt bit and bit 1 is the bus-error bit. Writing a one to a bit clears it and writing a zero leaves it. A `bus_err_evt` pulse sets bit 1.
- R3: The mask (index 5) is read-only. Writing ones to the unmask port (index 6) clears those mask bits. Writing ones to the mask-set port (index 7) sets them. Both ports read back 0.
- R4: `irq` is high exactly when a status bit is set and its mask bit is clear. It follows the registered state in the cycle after any write or event.
- R5: Core control (index 0) holds enables in bits 2 (continuous), 1 (health) and 0 (done). The flag word (index 1) shows continuous in bit 3, health in bit 1 and done in bit 0. Three things trigger a recompute: a core-control write, a `done_evt` pulse, or an accepted injection. On a recompute, the core-interrupt bit takes the value (continuous AND its enable) OR (health AND its enable) OR (done AND its enable).
- R6: Writing ones to core-control bits 5, 4 and 3 clears the continuous, health and done flags respectively. The core-interrupt bit is then recomputed in the same write.
- R7: Injections on `inj_hlth` and `inj_cont` have no effect while `src_en` is low.
- R8: When HW_VER is below 0x0200, a continuous injection is dropped unless the test-unit enable (config index 2, bit 1) is set. A health injection needs no such bit. When HW_VER is 0x0200 or above, neither injection needs it.
- R9: A `soft_rst` pulse clears all three flags and the core-interrupt bit. It leaves the bus-error bit, the mask and the enables unchanged.
- R10: When HW_VER is 0x0200 or above, the test-unit enable is forced to zero on write. When HW_VER is below 0x0200, writes to the auxiliary control register (index 3) are dropped and it keeps its reset value 0.
- R11: When an event that sets a status bit falls in the same cycle as a write-one-to-clear of that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word index |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read word index |
| rd_data | output | DW | Read data (combinational) |
| done_evt | input | 1 | Generation-complete pulse |
| bus_err_evt | input | 1 | Bus-error pulse |
| soft_rst | input | 1 | Soft reset pulse for the flags and the core-interrupt bit |
| src_en | input | 1 | Entropy source enabled |
| inj_hlth | input | 1 | Injected health-test failure pulse |
| inj_cont | input | 1 | Injected continuous-test failure pulse |
| irq | output | 1 | Interrupt output |

## Verification
Some events can land in the same cycle as a software write-one-to-clear of the status bit they set. This happens with a generation-complete pulse against a clear of the core-interrupt bit, and with a bus-error pulse against a clear of the bus-error bit. The bench raises the event and the clearing write on the same negative edge, so that both reach the same rising edge. It then reads the status word and expects the bit to be set. A separate check shows that an identical write with no event does clear the bit, so it is the event that keeps the bit set.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned HW_VER = 32'h0200,
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = 32,
  parameter int unsigned AUX_W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          done_evt,
  input  logic          bus_err_evt,
  input  logic          soft_rst,
  input  logic          src_en,
  input  logic          inj_hlth,
  input  logic          inj_cont,
  output logic          irq
);

  localparam bit            NEW_VER = (HW_VER >= 32'h0200);
  localparam logic [AW-1:0] A_CCTL  = AW'(0);
  localparam logic [AW-1:0] A_FLAGS = AW'(1);
  localparam logic [AW-1:0] A_CFG   = AW'(2);
  localparam logic [AW-1:0] A_AUX   = AW'(3);
  localparam logic [AW-1:0] A_STAT  = AW'(4);
  localparam logic [AW-1:0] A_MASK  = AW'(5);
  localparam logic [AW-1:0] A_UNM   = AW'(6);
  localparam logic [AW-1:0] A_MSET  = AW'(7);

  logic [2:0]       en_q, flg_q;
  logic             core_q, berr_q, tue_q;
  logic [1:0]       mask_q;
  logic [AUX_W-1:0] aux_q;

  logic             wr_cctl, wr_cfg, wr_aux, wr_stat, wr_unm, wr_mset;
  logic [2:0]       en_nx, clr, set, flg_nx;
  logic [1:0]       w1c;
  logic             acc_hlth, acc_cont, recompute, core_pend;

  assign wr_cctl = wr_en && (wr_addr == A_CCTL);
  assign wr_cfg  = wr_en && (wr_addr == A_CFG);
  assign wr_aux  = wr_en && (wr_addr == A_AUX);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_unm  = wr_en && (wr_addr == A_UNM);
  assign wr_mset = wr_en && (wr_addr == A_MSET);

  assign en_nx    = wr_cctl ? wr_data[2:0] : en_q;
  assign clr      = wr_cctl ? wr_data[5:3] : 3'b000;
  assign acc_hlth = src_en && inj_hlth;
  assign acc_cont = src_en && inj_cont && (NEW_VER || tue_q);
  assign set      = {acc_cont, acc_hlth, done_evt};
  assign flg_nx   = (flg_q & ~clr) | set;

  assign recompute = wr_cctl || done_evt || acc_hlth || acc_cont;
  assign core_pend = |(flg_nx & en_nx);
  assign w1c       = wr_stat ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flg_q  <= '0;
      core_q <= 1'b0;
    end else if (soft_rst) begin
      en_q   <= en_nx;
      flg_q  <= '0;
      core_q <= 1'b0;
    end else begin
      en_q   <= en_nx;
      flg_q  <= flg_nx;
      if (recompute)   core_q <= core_pend;
      else if (w1c[0]) core_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr_q <= 1'b0;
      mask_q <= 2'b11;
    end else begin
      berr_q <= bus_err_evt || (berr_q && !w1c[1]);
      if (wr_unm)       mask_q <= mask_q & ~wr_data[1:0];
      else if (wr_mset) mask_q <= mask_q | wr_data[1:0];
    end
  end

  generate
    if (NEW_VER) begin : g_new
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      aux_q <= '0;
        else if (wr_aux) aux_q <= wr_data[AUX_W-1:0];
      end
      assign tue_q = 1'b0;
    end else begin : g_old
      logic tue_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tue_r <= 1'b0;
        else if (wr_cfg) tue_r <= wr_data[1];
      end
      assign tue_q = tue_r;
      assign aux_q = '0;
    end
  endgenerate

  assign irq = |({berr_q, core_q} & ~mask_q);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CCTL:  rd_data = DW'(en_q);
      A_FLAGS: rd_data = DW'({flg_q[2], 1'b0, flg_q[1], flg_q[0]});
      A_CFG:   rd_data = DW'({tue_q, 1'b0});
      A_AUX:   rd_data = DW'(aux_q);
      A_STAT:  rd_data = DW'({berr_q, core_q});
      A_MASK:  rd_data = DW'(mask_q);
      default: rd_data = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data, wr_cfg};

endmodule

module irq_aggregator_chk #(
  parameter int unsigned HW_VER = 32'h0200,
  parameter int unsigned AW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          done_evt,
  input logic          bus_err_evt,
  input logic          soft_rst,
  input logic          src_en,
  input logic          irq,
  input logic [2:0]    flg_q,
  input logic          core_q,
  input logic          berr_q,
  input logic [1:0]    mask_q,
  input logic          tue_q
);
  localparam bit NEW_VER = (HW_VER >= 32'h0200);

  AST_MASK_PORTS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == AW'(6) || wr_addr == AW'(7))) |=> $stable(mask_q)); // R3
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b11) |-> !irq); // R4
  AST_BUSERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_evt |=> berr_q); // R2
  AST_NO_SRC_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_en && !done_evt && !soft_rst && !(wr_en && wr_addr == AW'(0))) |=> $stable(flg_q)); // R7
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flg_q == 3'b000) && !core_q); // R9
  AST_TUE_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    NEW_VER |-> !tue_q); // R10
endmodule

bind irq_aggregator irq_aggregator_chk #(.HW_VER(HW_VER), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .done_evt(done_evt), .bus_err_evt(bus_err_evt), .soft_rst(soft_rst),
  .src_en(src_en), .irq(irq), .flg_q(flg_q), .core_q(core_q),
  .berr_q(berr_q), .mask_q(mask_q), .tue_q(tue_q)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam logic [2:0] CCTL = 3'd0, FLAGS = 3'd1, CFG = 3'd2, AUX = 3'd3,
                         STAT = 3'd4, MASK = 3'd5, UNM = 3'd6, MSET = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, rd_data_o;
  logic done_evt = 0, bus_err_evt = 0, soft_rst = 0, src_en = 0, inj_hlth = 0, inj_cont = 0;
  logic irq, irq_o;
  int nvec = 0, nbad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.HW_VER(32'h0200)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_evt(done_evt), .bus_err_evt(bus_err_evt),
    .soft_rst(soft_rst), .src_en(src_en), .inj_hlth(inj_hlth), .inj_cont(inj_cont), .irq(irq));

  irq_aggregator #(.HW_VER(32'h0100)) u_old (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data_o), .done_evt(done_evt), .bus_err_evt(bus_err_evt),
    .soft_rst(soft_rst), .src_en(src_en), .inj_hlth(inj_hlth), .inj_cont(inj_cont), .irq(irq_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rdn(logic [2:0] a, logic [31:0] exp, string req);
    rd_addr = a; #0.5; chk(req, rd_data, exp);
  endtask

  task automatic rdo(logic [2:0] a, logic [31:0] exp, string req);
    rd_addr = a; #0.5; chk(req, rd_data_o, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic t_reset;
    rdn(STAT, 0, "R1 status"); rdn(MASK, 3, "R1 mask");
    rdn(FLAGS, 0, "R1 flags"); chk("R1 irq", irq, 0);
  endtask

  task automatic t_mask;
    wr(MASK, 0);        rdn(MASK, 3, "R3 direct write ignored");
    wr(UNM, 1);         rdn(MASK, 2, "R3 unmask bit0");
    rdn(UNM, 0, "R3 unmask reads zero");
    chk("R4 idle irq", irq, 0);
    pulse(bus_err_evt); rdn(STAT, 2, "R2 bus error set"); chk("R4 masked", irq, 0);
    wr(UNM, 2);         rdn(MASK, 0, "R3 unmask bit1"); chk("R4 unmasked", irq, 1);
    wr(STAT, 0);        rdn(STAT, 2, "R2 zero write keeps");
    wr(STAT, 2);        rdn(STAT, 0, "R2 w1c"); chk("R4 after clear", irq, 0);
    wr(MSET, 2);        rdn(MASK, 2, "R3 mask-set");
  endtask

  task automatic t_core;
    pulse(done_evt);    rdn(FLAGS, 1, "R5 done flag"); rdn(STAT, 0, "R5 disabled");
    wr(CCTL, 1);        rdn(STAT, 1, "R5 enable recompute"); chk("R4 core irq", irq, 1);
    wr(CCTL, 32'h09);   rdn(FLAGS, 0, "R6 clear done"); rdn(STAT, 0, "R6 recompute");
    chk("R4 irq drop", irq, 0);
    pulse(done_evt);    rdn(STAT, 1, "R5 done event");
    wr(STAT, 1);        rdn(STAT, 0, "R2 core w1c");
    wr(CCTL, 32'h09);   rdn(FLAGS, 0, "R6 clear again");
  endtask

  task automatic t_inject;
    @(negedge clk); inj_hlth = 1; inj_cont = 1;
    @(negedge clk); inj_hlth = 0; inj_cont = 0;
    rdn(FLAGS, 0, "R7 new ignored"); rdo(FLAGS, 0, "R7 old ignored");
    src_en = 1;
    wr(CCTL, 32'h06);
    pulse(inj_hlth);    rdn(FLAGS, 2, "R8 new health"); rdn(STAT, 1, "R5 health core");
    rdo(FLAGS, 2, "R8 old health");
    pulse(inj_cont);    rdn(FLAGS, 32'hA, "R8 new cont"); rdo(FLAGS, 2, "R8 old cont dropped");
    wr(CFG, 2);         rdo(CFG, 2, "R8 old tue set"); rdn(CFG, 0, "R10 new tue forced");
    pulse(inj_cont);    rdo(FLAGS, 32'hA, "R8 old cont accepted");
    wr(CCTL, 32'h3E);   rdn(FLAGS, 0, "R6 clear all"); rdn(STAT, 0, "R6 core low");
  endtask

  task automatic t_aux;
    wr(AUX, 32'hABCD);
    rdn(AUX, 32'hABCD, "R10 new aux"); rdo(AUX, 0, "R10 old aux dropped");
  endtask

  task automatic t_soft;
    wr(CCTL, 7);
    pulse(done_evt); pulse(bus_err_evt);
    rdn(STAT, 3, "R9 setup"); chk("R4 setup irq", irq, 1);
    pulse(soft_rst);
    rdn(FLAGS, 0, "R9 flags"); rdn(STAT, 2, "R9 status");
    rdn(MASK, 2, "R9 mask"); rdn(CCTL, 7, "R9 enables"); chk("R9 irq", irq, 0);
    wr(STAT, 2);
  endtask

  task automatic t_race;
    pulse(done_evt); rdn(STAT, 1, "R11 setup");
    @(negedge clk); done_evt = 1; wr_en = 1; wr_addr = STAT; wr_data = 1;
    @(negedge clk); done_evt = 0; wr_en = 0;
    rdn(STAT, 1, "R11 done beats clear");
    @(negedge clk); bus_err_evt = 1; wr_en = 1; wr_addr = STAT; wr_data = 2;
    @(negedge clk); bus_err_evt = 0; wr_en = 0;
    rdn(STAT, 3, "R11 bus error beats clear");
    wr(STAT, 3); rdn(STAT, 0, "R2 plain clear");
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_mask(); t_core(); t_inject(); t_aux(); t_soft(); t_race();
    finished = 1;
    report();
  end
endmodule